// File: doc/BRIEF.md
# Circular-Buffer Sample Fetcher

This block keeps a small local line store topped up with 64-bit words read from a circular region of memory, so that a downstream serializer can drain audio samples at its own pace. Software programs the first and last word addresses of the region, a capacity limit and a refill threshold, then enables the channel. The fetcher reads one 64-bit word at a time through a request/acknowledge memory port and steps its pointer by 8 bytes per word. After it has read the last word it starts again at the first word.

Software can read the current fetch address at any time. The play position in the ring is that address minus the start address. A reload is triggered only by a rising edge of the reload bit. It moves the pointer back to the start of the ring and empties the line store.

Top module: `ring_fetch_fifo`

## Requirements
- R1: Each accepted fetch reads the 64-bit word at the current pointer. The pointer then advances by 8 bytes. When the word just fetched is at the programmed last-word address, the pointer goes back to the start address instead, so the last-word address is inclusive and a ring of one word is legal.
- R2: At most one fetch is outstanding. `mem_req` stays high with a stable `mem_addr` until `mem_ack`. It is low in the cycle after the acknowledge.
- R3: A new request is raised only while the channel is enabled and the store fill is at or below the threshold field.
- R4: The line store holds at most (capacity field + 1) lines, and never more than LINES. After reset the capacity field is LINES-1 and the threshold field is LINES/2-1.
- R5: A write that changes the reload bit (register 1, bit 12) from 0 to 1 copies the start address into the pointer, empties the line store and cancels any outstanding request. Writing 1 while the bit is already 1 changes neither the pointer nor the stored data.
- R6: Register 4 reads back the current fetch address as a byte address.
- R7: The enable bit (register 0, bit 31) gates fetching, and it is 0 after reset. Clearing it lowers `mem_req` by the second clock edge, and no later acknowledge is taken. Data already in the store is kept and can still be popped.
- R8: `pop_valid` is high whenever the store is non-empty. Words leave through `pop_data` in the order they were fetched, one word per cycle with `pop_ready` high.
- R9: Register map: 0 control (bit 31 enable); 1 store control (bits 31:24 capacity minus one, bits 23:16 threshold, bit 12 reload; only the low log2(LINES) bits of each field are kept); 2 start address; 3 last-word address; 4 current address (read only). Address bits 2:0 are ignored and read as zero. Unmapped registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write index |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read index |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the requested 64-bit word |
| mem_ack | input | 1 | Memory acknowledge, with data |
| mem_rdata | input | 64 | Memory read data, valid with `mem_ack` |
| pop_valid | output | 1 | Store holds at least one word |
| pop_data | output | 64 | Oldest stored word |
| pop_ready | input | 1 | Consumer takes the word this cycle |

## Verification
The hardest state to reach from the ports is a request that is still waiting when the channel is disabled. The bench's memory model gets there by acknowledging a limited number of requests and then holding the next one unanswered. The test then clears enable and checks that the request goes away, that no later acknowledge gets in, and that the earlier word can still be popped. Other sweeps step the threshold and capacity fields across their full range with the consumer stalled, where the number of fetches is known arithmetically. They also stream rings of one, two and three words, including a ring at the top of the address space, under a rotating memory latency.

// File: rtl/rfetch_pkg.sv
package rfetch_pkg;

    localparam int REG_W      = 32;
    localparam int BEAT_W     = 64;
    localparam int BEAT_SHIFT = 3;

    localparam int EN_BIT     = 31;
    localparam int LOAD_BIT   = 12;
    localparam int THR_LSB    = 16;
    localparam int DEP_LSB    = 24;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_STORE  = 3'd1,
        RA_START  = 3'd2,
        RA_LAST   = 3'd3,
        RA_CUR    = 3'd4
    } reg_idx_e;

endpackage

// File: rtl/rfetch_regs.sv
module rfetch_regs
    import rfetch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 4,
    localparam int WA_W  = ADDR_W - BEAT_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_idx,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [2:0]        rd_idx,
    output logic [REG_W-1:0]  rd_data,
    input  logic [WA_W-1:0]   cur_wa,
    output logic              en,
    output logic              load_pulse,
    output logic [WA_W-1:0]   start_wa,
    output logic [WA_W-1:0]   last_wa,
    output logic [LINE_W-1:0] depth_m1,
    output logic [LINE_W-1:0] thr
);

    typedef struct packed {
        logic              en;
        logic              load;
        logic [LINE_W-1:0] depth;
        logic [LINE_W-1:0] thr;
        logic [WA_W-1:0]   start;
        logic [WA_W-1:0]   last;
    } regs_t;

    localparam logic [LINE_W-1:0] DEPTH_RST = '1;
    localparam logic [LINE_W-1:0] THR_RST   = {1'b0, {(LINE_W-1){1'b1}}};

    regs_t r_d, r_q;
    logic  wdata_unused;

    assign wdata_unused = ^{wr_data[BEAT_SHIFT-1:0], wr_data[REG_W-1 -: 1]};

    always_comb begin
        r_d        = r_q;
        load_pulse = 1'b0;
        if (wr_en) begin
            case (wr_idx)
                RA_CTRL: begin
                    r_d.en = wr_data[EN_BIT];
                end
                RA_STORE: begin
                    r_d.load   = wr_data[LOAD_BIT];
                    r_d.depth  = wr_data[DEP_LSB +: LINE_W];
                    r_d.thr    = wr_data[THR_LSB +: LINE_W];
                    load_pulse = wr_data[LOAD_BIT] && !r_q.load;
                end
                RA_START: begin
                    r_d.start = wr_data[ADDR_W-1:BEAT_SHIFT];
                end
                RA_LAST: begin
                    r_d.last = wr_data[ADDR_W-1:BEAT_SHIFT];
                end
                default: begin
                    r_d = r_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.en    <= 1'b0;
            r_q.load  <= 1'b0;
            r_q.depth <= DEPTH_RST;
            r_q.thr   <= THR_RST;
            r_q.start <= '0;
            r_q.last  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_idx)
            RA_CTRL: begin
                rd_data[EN_BIT] = r_q.en;
            end
            RA_STORE: begin
                rd_data[DEP_LSB +: LINE_W] = r_q.depth;
                rd_data[THR_LSB +: LINE_W] = r_q.thr;
                rd_data[LOAD_BIT]          = r_q.load;
            end
            RA_START: rd_data = REG_W'({r_q.start, {BEAT_SHIFT{1'b0}}});
            RA_LAST:  rd_data = REG_W'({r_q.last, {BEAT_SHIFT{1'b0}}});
            RA_CUR:   rd_data = REG_W'({cur_wa, {BEAT_SHIFT{1'b0}}});
            default:  rd_data = '0;
        endcase
    end

    assign en       = r_q.en;
    assign start_wa = r_q.start;
    assign last_wa  = r_q.last;
    assign depth_m1 = r_q.depth;
    assign thr      = r_q.thr;

endmodule

// File: rtl/rfetch_ptr.sv
module rfetch_ptr
    import rfetch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINES  = 16,
    localparam int WA_W   = ADDR_W - BEAT_SHIFT,
    localparam int LINE_W = $clog2(LINES),
    localparam int CNT_W  = $clog2(LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load_pulse,
    input  logic [WA_W-1:0]   start_wa,
    input  logic [WA_W-1:0]   last_wa,
    input  logic [LINE_W-1:0] depth_m1,
    input  logic [LINE_W-1:0] thr,
    input  logic [CNT_W-1:0]  fill,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic [WA_W-1:0]   cur_wa,
    output logic              push
);

    typedef struct packed {
        logic            req;
        logic [WA_W-1:0] cur;
    } ptr_t;

    ptr_t p_d, p_q;
    logic room;
    logic below_thr;
    logic at_last;

    assign room      = (fill <= CNT_W'(depth_m1)) && (fill < CNT_W'(LINES));
    assign below_thr = fill <= CNT_W'(thr);
    assign at_last   = p_q.cur == last_wa;

    always_comb begin
        p_d  = p_q;
        push = 1'b0;
        if (load_pulse) begin
            p_d.cur = start_wa;
            p_d.req = 1'b0;
        end else if (!en) begin
            p_d.req = 1'b0;
        end else if (p_q.req) begin
            if (mem_ack) begin
                push    = 1'b1;
                p_d.req = 1'b0;
                p_d.cur = at_last ? start_wa : p_q.cur + WA_W'(1);
            end
        end else if (room && below_thr) begin
            p_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign mem_req = p_q.req;
    assign cur_wa  = p_q.cur;

endmodule

// File: rtl/rfetch_store.sv
module rfetch_store
    import rfetch_pkg::*;
#(
    parameter int LINES   = 16,
    localparam int LINE_W = $clog2(LINES),
    localparam int CNT_W  = $clog2(LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [BEAT_W-1:0] push_data,
    input  logic              pop_ready,
    output logic              pop_valid,
    output logic [BEAT_W-1:0] pop_data,
    output logic [CNT_W-1:0]  fill
);

    typedef struct packed {
        logic [LINE_W-1:0] rd;
        logic [LINE_W-1:0] wr;
        logic [CNT_W-1:0]  cnt;
    } st_t;

    st_t               s_d, s_q;
    logic [BEAT_W-1:0] mem_d [LINES];
    logic [BEAT_W-1:0] mem_q [LINES];
    logic              do_push;
    logic              do_pop;

    function automatic logic [LINE_W-1:0] step(input logic [LINE_W-1:0] p);
        return (p == LINE_W'(LINES - 1)) ? '0 : p + LINE_W'(1);
    endfunction

    assign do_pop  = pop_ready && (s_q.cnt != '0);
    assign do_push = push && (s_q.cnt < CNT_W'(LINES));

    always_comb begin
        s_d   = s_q;
        mem_d = mem_q;
        if (flush) begin
            s_d = '0;
        end else begin
            if (do_push) begin
                mem_d[s_q.wr] = push_data;
                s_d.wr        = step(s_q.wr);
            end
            if (do_pop) begin
                s_d.rd = step(s_q.rd);
            end
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + CNT_W'(1);
                2'b01:   s_d.cnt = s_q.cnt - CNT_W'(1);
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign pop_valid = s_q.cnt != '0;
    assign pop_data  = mem_q[s_q.rd];
    assign fill      = s_q.cnt;

endmodule

// File: rtl/ring_fetch_fifo.sv
module ring_fetch_fifo
    import rfetch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_waddr,
    input  logic [31:0]       reg_wdata,
    input  logic [2:0]        reg_raddr,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [63:0]       mem_rdata,
    output logic              pop_valid,
    output logic [63:0]       pop_data,
    input  logic              pop_ready
);

    localparam int WA_W   = ADDR_W - BEAT_SHIFT;
    localparam int LINE_W = $clog2(LINES);
    localparam int CNT_W  = $clog2(LINES + 1);

    logic              en;
    logic              load_pulse;
    logic [WA_W-1:0]   start_wa;
    logic [WA_W-1:0]   last_wa;
    logic [WA_W-1:0]   cur_wa;
    logic [LINE_W-1:0] depth_m1;
    logic [LINE_W-1:0] thr;
    logic [CNT_W-1:0]  fill;
    logic              push;

    rfetch_regs #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .wr_idx     (reg_waddr),
        .wr_data    (reg_wdata),
        .rd_idx     (reg_raddr),
        .rd_data    (reg_rdata),
        .cur_wa     (cur_wa),
        .en         (en),
        .load_pulse (load_pulse),
        .start_wa   (start_wa),
        .last_wa    (last_wa),
        .depth_m1   (depth_m1),
        .thr        (thr)
    );

    rfetch_ptr #(.ADDR_W(ADDR_W), .LINES(LINES)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .load_pulse (load_pulse),
        .start_wa   (start_wa),
        .last_wa    (last_wa),
        .depth_m1   (depth_m1),
        .thr        (thr),
        .fill       (fill),
        .mem_ack    (mem_ack),
        .mem_req    (mem_req),
        .cur_wa     (cur_wa),
        .push       (push)
    );

    rfetch_store #(.LINES(LINES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (load_pulse),
        .push       (push),
        .push_data  (mem_rdata),
        .pop_ready  (pop_ready),
        .pop_valid  (pop_valid),
        .pop_data   (pop_data),
        .fill       (fill)
    );

    assign mem_addr = {cur_wa, {BEAT_SHIFT{1'b0}}};

endmodule

// File: rtl/rfetch_chk.sv
module rfetch_chk #(
    parameter int ADDR_W = 32,
    parameter int LINES  = 16,
    localparam int WA_W   = ADDR_W - 3,
    localparam int LINE_W = $clog2(LINES),
    localparam int CNT_W  = $clog2(LINES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              load_pulse,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WA_W-1:0]   start_wa,
    input logic [WA_W-1:0]   last_wa,
    input logic [WA_W-1:0]   cur_wa,
    input logic [CNT_W-1:0]  fill,
    input logic [LINE_W-1:0] thr
);

    // R1
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && en && !load_pulse) |=>
            cur_wa == (($past(cur_wa) == $past(last_wa)) ? $past(start_wa)
                                                         : $past(cur_wa) + WA_W'(1)));

    // R2
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && en && !load_pulse) |=> (mem_req && $stable(mem_addr)));

    // R2
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);

    // R3
    thr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> ($past(fill) <= CNT_W'($past(thr)) && $past(en)));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(LINES));

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> (!mem_req && cur_wa == $past(start_wa) && fill == '0));

    // R7
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mem_req);

endmodule

bind ring_fetch_fifo rfetch_chk #(.ADDR_W(ADDR_W), .LINES(LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .load_pulse (load_pulse),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .start_wa   (start_wa),
    .last_wa    (last_wa),
    .cur_wa     (cur_wa),
    .fill       (fill),
    .thr        (thr)
);

// File: tb/ring_fetch_fifo_test.sv
module ring_fetch_fifo_test;

    localparam int LINES = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        pop_valid;
    logic [63:0] pop_data;
    logic        pop_ready = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int ack_cnt = 0;
    int ack_limit = 0;
    int lat_sel = 0;
    int lat_cnt = 0;
    bit lat_rotate = 1'b0;
    int pop_cnt = 0;
    logic [31:0] ring_st = '0;
    logic [31:0] ring_fin = '0;
    logic [31:0] exp_fetch = '0;
    logic [31:0] exp_pop = '0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    ring_fetch_fifo #(.ADDR_W(32), .LINES(LINES)) uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .pop_valid(pop_valid), .pop_data(pop_data), .pop_ready(pop_ready)
    );

    function automatic logic [63:0] pattern(input logic [31:0] a);
        return {a ^ 32'hA5A5_0000, a};
    endfunction

    function automatic logic [31:0] ring_next(input logic [31:0] a);
        return (a == ring_fin) ? ring_st : a + 32'd8;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (rst_n && mem_req && ack_cnt < ack_limit) begin
            if (lat_cnt >= lat_sel) begin
                chk(mem_addr == exp_fetch, "R1 fetch address", 64'(mem_addr), 64'(exp_fetch));
                mem_ack   = 1'b1;
                mem_rdata = pattern(mem_addr);
                exp_fetch = ring_next(exp_fetch);
                ack_cnt++;
                lat_cnt = 0;
                if (lat_rotate) lat_sel = (lat_sel + 1) % 4;
            end else begin
                lat_cnt++;
            end
        end
    end

    // consumer
    always @(negedge clk) begin
        if (rst_n && pop_ready && pop_valid) begin
            chk(pop_data == pattern(exp_pop), "R8 pop order", pop_data, pattern(exp_pop));
            exp_pop = ring_next(exp_pop);
            pop_cnt++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_raddr = a;
        #1 v = reg_rdata;
    endtask

    task automatic set_ready(input logic v);
        @(posedge clk);
        #1 pop_ready = v;
    endtask

    function automatic logic [31:0] store_word(input int dep, input int thr, input bit ld);
        return (32'(dep) << 24) | (32'(thr) << 16) | (32'(ld) << 12);
    endfunction

    task automatic reload(input logic [31:0] st, input logic [31:0] fin, input int thr, input int dep);
        wr_reg(3'd2, st);
        wr_reg(3'd3, fin);
        ring_st = st; ring_fin = fin;
        exp_fetch = st; exp_pop = st;
        wr_reg(3'd1, store_word(dep, thr, 1'b0));
        wr_reg(3'd1, store_word(dep, thr, 1'b1));
        ack_cnt = 0; pop_cnt = 0;
    endtask

    task automatic halt();
        @(posedge clk);
        #1 ack_limit = ack_cnt;
        wr_reg(3'd0, 32'h0);
        cyc(3);
    endtask

    task automatic drain();
        set_ready(1'b1);
        cyc(LINES + 6);
        set_ready(1'b0);
        cyc(2);
    endtask

    initial begin
        #1_200_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cyc(5);
        // reset state: R7, R4, R6
        chk(mem_req == 1'b0, "R7 no request after reset", 64'(mem_req), 64'd0);
        chk(pop_valid == 1'b0, "R8 empty after reset", 64'(pop_valid), 64'd0);
        rst_n = 1'b1;
        cyc(2);
        rd_reg(3'd1, rv);
        chk(rv == store_word(LINES - 1, LINES / 2 - 1, 1'b0), "R4 store control default", 64'(rv),
            64'(store_word(LINES - 1, LINES / 2 - 1, 1'b0)));
        rd_reg(3'd0, rv);
        chk(rv == 32'h0, "R7 enable clear after reset", 64'(rv), 64'd0);
        rd_reg(3'd4, rv);
        chk(rv == 32'h0, "R6 current address after reset", 64'(rv), 64'd0);

        // R9: low address bits and unmapped registers
        wr_reg(3'd2, 32'h0000_1007);
        rd_reg(3'd2, rv);
        chk(rv == 32'h0000_1000, "R9 low bits ignored", 64'(rv), 64'h1000);
        rd_reg(3'd6, rv);
        chk(rv == 32'h0, "R9 unmapped reads zero", 64'(rv), 64'd0);
        wr_reg(3'd1, 32'hFF00_0000 | store_word(2, 1, 1'b0));
        rd_reg(3'd1, rv);
        chk(rv == store_word(LINES - 1, 1, 1'b0), "R9 field width", 64'(rv),
            64'(store_word(LINES - 1, 1, 1'b0)));

        // R3 threshold sweep, consumer stalled, ring of 5 words
        for (int t = 0; t < LINES; t++) begin
            reload(32'h0000_1000, 32'h0000_1020, t, LINES - 1);
            lat_rotate = 1'b0; lat_sel = t % 4; lat_cnt = 0; ack_limit = 1000;
            wr_reg(3'd0, 32'h8000_0000);
            cyc(80);
            chk(ack_cnt == t + 1, "R3 fetches stop above threshold", 64'(ack_cnt), 64'(t + 1));
            rd_reg(3'd4, rv);
            chk(rv == 32'h1000 + 32'(8 * ((t + 1) % 5)), "R6 status after fetches", 64'(rv),
                64'(32'h1000 + 32'(8 * ((t + 1) % 5))));
            halt();
            drain();
            chk(pop_cnt == t + 1, "R8 all fetched words popped", 64'(pop_cnt), 64'(t + 1));
        end

        // R4 capacity cap with threshold at max
        for (int d = 0; d < LINES - 1; d += 2) begin
            reload(32'h0000_2000, 32'h0000_2038, LINES - 1, d);
            lat_sel = 1; lat_cnt = 0; ack_limit = 1000;
            wr_reg(3'd0, 32'h8000_0000);
            cyc(60);
            chk(ack_cnt == d + 1, "R4 capacity limits fetches", 64'(ack_cnt), 64'(d + 1));
            halt();
            drain();
            chk(pop_cnt == d + 1, "R4 stored lines popped", 64'(pop_cnt), 64'(d + 1));
        end

        // R1 / R8 streaming over small rings with wrap
        for (int k = 0; k < 3; k++) begin
            logic [31:0] st, fin;
            st  = (k == 0) ? 32'h0000_3000 : (k == 1) ? 32'h0000_4000 : 32'hFFFF_FFF0;
            fin = (k == 0) ? 32'h0000_3000 : (k == 1) ? 32'h0000_4010 : 32'hFFFF_FFF8;
            reload(st, fin, 3, LINES - 1);
            lat_rotate = 1'b1; lat_sel = 0; lat_cnt = 0; ack_limit = 100000;
            set_ready(1'b1);
            wr_reg(3'd0, 32'h8000_0000);
            cyc(200);
            halt();
            drain();
            lat_rotate = 1'b0;
            chk(pop_cnt >= 20, "R1 streaming progress", 64'(pop_cnt), 64'd20);
            chk(pop_cnt == ack_cnt, "R8 pops equal fetches", 64'(pop_cnt), 64'(ack_cnt));
        end

        // R5 reload edge only
        reload(32'h0000_4000, 32'h0000_4010, 3, LINES - 1);
        lat_sel = 0; lat_cnt = 0; ack_limit = 1000;
        wr_reg(3'd0, 32'h8000_0000);
        cyc(30);
        halt();
        rd_reg(3'd4, rv);
        chk(rv == 32'h4008, "R6 status after four fetches", 64'(rv), 64'h4008);
        wr_reg(3'd1, store_word(LINES - 1, 3, 1'b1));
        rd_reg(3'd4, rv);
        chk(rv == 32'h4008, "R5 held reload bit no effect", 64'(rv), 64'h4008);
        chk(pop_valid == 1'b1, "R5 held reload keeps data", 64'(pop_valid), 64'd1);
        wr_reg(3'd1, store_word(LINES - 1, 3, 1'b0));
        wr_reg(3'd1, store_word(LINES - 1, 3, 1'b1));
        cyc(1);
        rd_reg(3'd4, rv);
        chk(rv == 32'h4000, "R5 rising edge reloads pointer", 64'(rv), 64'h4000);
        chk(pop_valid == 1'b0, "R5 reload empties store", 64'(pop_valid), 64'd0);

        // R7 disable drops pending request
        reload(32'h0000_5000, 32'h0000_5018, 3, LINES - 1);
        lat_sel = 0; lat_cnt = 0; ack_limit = 1;
        wr_reg(3'd0, 32'h8000_0000);
        cyc(20);
        chk(ack_cnt == 1, "R7 first fetch done", 64'(ack_cnt), 64'd1);
        chk(mem_req == 1'b1, "R2 second request waiting", 64'(mem_req), 64'd1);
        wr_reg(3'd0, 32'h0);
        cyc(1);
        chk(mem_req == 1'b0, "R7 disable drops request", 64'(mem_req), 64'd0);
        ack_limit = 100;
        cyc(10);
        chk(ack_cnt == 1, "R7 no fetch while disabled", 64'(ack_cnt), 64'd1);
        rd_reg(3'd4, rv);
        chk(rv == 32'h5008, "R6 dropped request keeps pointer", 64'(rv), 64'h5008);
        chk(pop_valid == 1'b1, "R7 data kept after disable", 64'(pop_valid), 64'd1);
        drain();
        chk(pop_cnt == 1, "R7 kept word popped", 64'(pop_cnt), 64'd1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule